// File: doc/BRIEF.md
# 8-bit Load Instruction Sequencer

This block fetches and executes the 8-bit load group of a small accumulator machine. It covers moves between registers, immediate loads, stores of a register through the HL pair, stores through an index register plus a signed displacement, and the four prefixed transfers between the accumulator and the interrupt-vector (I) and refresh (R) registers. One clock is one T-state. The block steps through the machine cycles of each instruction with the exact T-state count. It reads every instruction byte from a byte-wide fetch port addressed by its own program counter.

Results land in an internal register file. A read-select port exposes it, and the I register, the R register and the flag byte are driven out directly. Stores go out on a one-cycle memory write strobe with address and data. A `done` strobe marks the last T-state of every instruction, so cycle counts can be compared from outside. The two index registers are fixed by parameters.

Top module: `load8_seq`

## Requirements
- R1: Opcode 01 ddd sss, where neither field is 110, copies register sss into register ddd. Register codes are B=000, C=001, D=010, E=011, H=100, L=101 and A=111. It takes 4 T-states, consumes 1 byte and leaves the flags unchanged.
- R2: Opcode 00 rrr 110 with rrr not 110, followed by a data byte, loads that byte into register rrr. It takes 7 T-states and consumes 2 bytes.
- R3: Opcode 01110 rrr with rrr not 110 writes register rrr to address {H,L}. It takes 7 T-states. `mem_we` is high for exactly one cycle, the last T-state, with `mem_addr` and `mem_wdata` valid.
- R4: Prefix 0xDD (IX) or 0xFD (IY), then 01110 rrr, then a displacement byte, writes register rrr to the index value plus the sign-extended displacement. It takes 19 T-states and consumes 3 bytes, and the write comes on the last T-state.
- R5: Prefix 0xED then 0x47 copies A to I, and 0xED then 0x4F copies A to R. Both take 9 T-states and leave the flags unchanged.
- R6: Prefix 0xED then 0x57 (A from I) or 0x5F (A from R) takes 9 T-states. Flag byte: bit 7 S gets result bit 7, bit 6 Z is set for a zero result, bit 4 H and bit 1 N are cleared, bit 0 C and bits 5 and 3 are kept.
- R7: For A from I or R, P/V (flag bit 2) takes the value of `iff2` in the last T-state. It is forced to 0 if `int_req` was high in any T-state of that instruction.
- R8: `done` is high during exactly the last T-state of each instruction. `fetch_addr` rises by one for every byte consumed and never changes otherwise.
- R9: Reset clears all registers, I, R, the flags and `fetch_addr`. `done` and `mem_we` are low while reset is held.
- R10: Unsupported opcodes change no register, flag or memory. A single byte (including 0x46 and 0x76) takes 4 T-states. A 0xDD/0xFD prefix with a non-store opcode takes 8 T-states. A 0xED prefix with an unlisted second byte takes 9 T-states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | output | 16 | Address of the next instruction byte |
| fetch_data | input | 8 | Byte at `fetch_addr` |
| iff2 | input | 1 | Interrupt-enable copy sampled into P/V |
| int_req | input | 1 | Interrupt seen during the current instruction |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| rd_sel | input | 3 | Register code to read |
| rd_data | output | 8 | Contents of the selected register |
| i_reg | output | 8 | Interrupt-vector register |
| r_reg | output | 8 | Refresh register |
| flags | output | 8 | Flag byte (S7 Z6 H4 PV2 N1 C0) |
| done | output | 1 | Last T-state of an instruction |

## Verification
The bench drives inputs and samples outputs on falling edges, and counts falling edges from the start of each instruction until `done` is seen. `done`, `mem_we`, `mem_addr` and `mem_wdata` are checked in that same last T-state. Register, I, R and flag results are written at the clock edge that ends the last T-state. The bench therefore reads them one falling edge later, in the first T-state of the next instruction, which is too early for that instruction to change anything. `fetch_addr` is compared at that same point against the running byte total. The interrupt pulse for the P/V override is raised in the first T-state of the instruction it belongs to.

// File: rtl/load8_pkg.sv
package load8_pkg;

    typedef enum logic [2:0] {
        PH_OP   = 3'd0,
        PH_OPX  = 3'd1,
        PH_OPE  = 3'd2,
        PH_IMM  = 3'd3,
        PH_DISP = 3'd4,
        PH_CALC = 3'd5,
        PH_WR   = 3'd6
    } phase_e;

    typedef enum logic [2:0] {
        OC_NOP     = 3'd0,
        OC_MOVE    = 3'd1,
        OC_IMM     = 3'd2,
        OC_STORE   = 3'd3,
        OC_PFX_IDX = 3'd4,
        OC_PFX_EXT = 3'd5
    } op_class_e;

    localparam logic [2:0] CODE_MEM = 3'b110;
    localparam logic [2:0] CODE_A   = 3'b111;
    localparam logic [2:0] CODE_H   = 3'b100;
    localparam logic [2:0] CODE_L   = 3'b101;

    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_H  = 4;
    localparam int FLG_PV = 2;
    localparam int FLG_N  = 1;

    function automatic logic [2:0] phase_len(phase_e ph);
        case (ph)
            PH_OP, PH_OPX:    return 3'd4;
            PH_OPE, PH_CALC:  return 3'd5;
            default:          return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/load8_decode.sv
module load8_decode
    import load8_pkg::*;
(
    input  logic [7:0] op,
    output op_class_e  cls,
    output logic [2:0] dst,
    output logic [2:0] src
);
    always_comb begin
        dst = op[5:3];
        src = op[2:0];
        cls = OC_NOP;
        if (op == 8'hDD || op == 8'hFD) begin
            cls = OC_PFX_IDX;
        end else if (op == 8'hED) begin
            cls = OC_PFX_EXT;
        end else if (op[7:6] == 2'b01) begin
            if (op[5:3] == CODE_MEM && op[2:0] != CODE_MEM)
                cls = OC_STORE;
            else if (op[5:3] != CODE_MEM && op[2:0] != CODE_MEM)
                cls = OC_MOVE;
        end else if (op[7:6] == 2'b00 && op[2:0] == CODE_MEM && op[5:3] != CODE_MEM) begin
            cls = OC_IMM;
        end
    end
endmodule

// File: rtl/load8_xfer.sv
module load8_xfer
    import load8_pkg::*;
(
    input  logic [7:0] op,
    input  logic [7:0] i_val,
    input  logic [7:0] r_val,
    input  logic [7:0] flags_in,
    input  logic       iff2,
    input  logic       irq_seen,
    output logic       wr_acc,
    output logic       wr_i,
    output logic       wr_r,
    output logic [7:0] acc_new,
    output logic [7:0] flags_new
);
    always_comb begin
        wr_acc  = 1'b0;
        wr_i    = 1'b0;
        wr_r    = 1'b0;
        acc_new = i_val;
        case (op)
            8'h57: wr_acc = 1'b1;
            8'h5F: begin wr_acc = 1'b1; acc_new = r_val; end
            8'h47: wr_i = 1'b1;
            8'h4F: wr_r = 1'b1;
            default: ;
        endcase
        flags_new = flags_in;
        if (wr_acc) begin
            flags_new[FLG_S]  = acc_new[7];
            flags_new[FLG_Z]  = (acc_new == 8'h00);
            flags_new[FLG_H]  = 1'b0;
            flags_new[FLG_PV] = iff2 & ~irq_seen;
            flags_new[FLG_N]  = 1'b0;
        end
    end
endmodule

// File: rtl/load8_seq.sv
module load8_seq
    import load8_pkg::*;
#(
    parameter logic [15:0] IX_INIT = 16'h1000,
    parameter logic [15:0] IY_INIT = 16'h2000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] fetch_addr,
    input  logic [7:0]  fetch_data,
    input  logic        iff2,
    input  logic        int_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [2:0]  rd_sel,
    output logic [7:0]  rd_data,
    output logic [7:0]  i_reg,
    output logic [7:0]  r_reg,
    output logic [7:0]  flags,
    output logic        done
);
    typedef struct packed {
        phase_e          phase;
        logic [2:0]      tcnt;
        logic [15:0]     pc;
        logic [7:0][7:0] regs;
        logic [7:0]      i;
        logic [7:0]      r;
        logic [7:0]      flg;
        logic            idx_sel;
        logic [2:0]      dst;
        logic [15:0]     addr;
        logic [7:0]      wdata;
        logic            intr;
    } seq_t;

    seq_t st_q, st_d;

    op_class_e  cls;
    logic [2:0] f_dst, f_src;
    logic       x_wr_acc, x_wr_i, x_wr_r;
    logic [7:0] x_acc, x_flags;
    logic       irq_seen;
    logic       last_t;
    logic       we_d;
    logic       done_d;
    logic [15:0] idx_base;

    assign irq_seen = st_q.intr | int_req;
    assign last_t   = (st_q.tcnt == phase_len(st_q.phase) - 3'd1);
    assign idx_base = st_q.idx_sel ? IY_INIT : IX_INIT;

    load8_decode u_dec (
        .op  (fetch_data),
        .cls (cls),
        .dst (f_dst),
        .src (f_src)
    );

    load8_xfer u_xfer (
        .op        (fetch_data),
        .i_val     (st_q.i),
        .r_val     (st_q.r),
        .flags_in  (st_q.flg),
        .iff2      (iff2),
        .irq_seen  (irq_seen),
        .wr_acc    (x_wr_acc),
        .wr_i      (x_wr_i),
        .wr_r      (x_wr_r),
        .acc_new   (x_acc),
        .flags_new (x_flags)
    );

    always_comb begin
        st_d   = st_q;
        we_d   = 1'b0;
        done_d = 1'b0;
        if (!last_t) begin
            st_d.tcnt = st_q.tcnt + 3'd1;
        end else begin
            st_d.tcnt = 3'd0;
            case (st_q.phase)
                PH_OP: begin
                    st_d.pc = st_q.pc + 16'd1;
                    case (cls)
                        OC_MOVE: begin
                            st_d.regs[f_dst] = st_q.regs[f_src];
                            done_d = 1'b1;
                        end
                        OC_IMM: begin
                            st_d.dst   = f_dst;
                            st_d.phase = PH_IMM;
                        end
                        OC_STORE: begin
                            st_d.addr  = {st_q.regs[CODE_H], st_q.regs[CODE_L]};
                            st_d.wdata = st_q.regs[f_src];
                            st_d.phase = PH_WR;
                        end
                        OC_PFX_IDX: begin
                            st_d.idx_sel = fetch_data[5];
                            st_d.phase   = PH_OPX;
                        end
                        OC_PFX_EXT: st_d.phase = PH_OPE;
                        default:    done_d = 1'b1;
                    endcase
                end
                PH_OPX: begin
                    st_d.pc = st_q.pc + 16'd1;
                    if (cls == OC_STORE) begin
                        st_d.wdata = st_q.regs[f_src];
                        st_d.phase = PH_DISP;
                    end else begin
                        done_d = 1'b1;
                    end
                end
                PH_DISP: begin
                    st_d.pc    = st_q.pc + 16'd1;
                    st_d.addr  = idx_base + {{8{fetch_data[7]}}, fetch_data};
                    st_d.phase = PH_CALC;
                end
                PH_CALC: st_d.phase = PH_WR;
                PH_WR: begin
                    we_d   = 1'b1;
                    done_d = 1'b1;
                end
                PH_IMM: begin
                    st_d.pc = st_q.pc + 16'd1;
                    st_d.regs[st_q.dst] = fetch_data;
                    done_d = 1'b1;
                end
                PH_OPE: begin
                    st_d.pc = st_q.pc + 16'd1;
                    if (x_wr_acc) st_d.regs[CODE_A] = x_acc;
                    if (x_wr_i)   st_d.i = st_q.regs[CODE_A];
                    if (x_wr_r)   st_d.r = st_q.regs[CODE_A];
                    st_d.flg = x_flags;
                    done_d   = 1'b1;
                end
                default: done_d = 1'b1;
            endcase
            if (done_d) st_d.phase = PH_OP;
        end
        st_d.intr = done_d ? 1'b0 : irq_seen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr = st_q.pc;
    assign mem_we     = we_d & rst_n;
    assign mem_addr   = st_q.addr;
    assign mem_wdata  = st_q.wdata;
    assign rd_data    = st_q.regs[rd_sel];
    assign i_reg      = st_q.i;
    assign r_reg      = st_q.r;
    assign flags      = st_q.flg;
    assign done       = done_d & rst_n;

    p_we_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> done);

    p_tcnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tcnt < phase_len(st_q.phase));

    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr != $past(fetch_addr)) |-> (fetch_addr == $past(fetch_addr) + 16'd1));

    p_done_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_q.phase == PH_OP && st_q.tcnt == 3'd0));

    p_acc_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.phase == PH_OPE && x_wr_acc) |=>
        (flags[FLG_S] == st_q.regs[CODE_A][7] &&
         flags[FLG_Z] == (st_q.regs[CODE_A] == 8'h00) &&
         !flags[FLG_H] && !flags[FLG_N]));

    p_pv_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.phase == PH_OPE && x_wr_acc && irq_seen) |=> !flags[FLG_PV]);

endmodule

// File: tb/load8_seq_bench.sv
module load8_seq_bench;
    typedef struct packed {
        logic [31:0] code;
        logic [2:0]  nb;
        logic [4:0]  tst;
        logic        iff2;
        logic        irq;
        logic [2:0]  kind;
        logic [2:0]  sel;
        logic [7:0]  dat;
        logic [15:0] addr;
    } vec_t;

    localparam int NV = 33;
    localparam logic [2:0] K_NONE = 3'd0, K_REG = 3'd1, K_MEM = 3'd2,
                           K_FLG = 3'd3, K_I = 3'd4, K_R = 3'd5;

    localparam vec_t TBL [NV] = '{
        '{32'h3E850000, 3'd2, 5'd7,  1'b0, 1'b0, K_REG, 3'd7, 8'h85, 16'h0},
        '{32'h06000000, 3'd2, 5'd7,  1'b0, 1'b0, K_REG, 3'd0, 8'h00, 16'h0},
        '{32'h0E7F0000, 3'd2, 5'd7,  1'b0, 1'b0, K_REG, 3'd1, 8'h7F, 16'h0},
        '{32'h26400000, 3'd2, 5'd7,  1'b0, 1'b0, K_REG, 3'd4, 8'h40, 16'h0},
        '{32'h2E120000, 3'd2, 5'd7,  1'b0, 1'b0, K_REG, 3'd5, 8'h12, 16'h0},
        '{32'h50000000, 3'd1, 5'd4,  1'b0, 1'b0, K_REG, 3'd2, 8'h00, 16'h0},
        '{32'h59000000, 3'd1, 5'd4,  1'b0, 1'b0, K_REG, 3'd3, 8'h7F, 16'h0},
        '{32'h78000000, 3'd1, 5'd4,  1'b0, 1'b0, K_FLG, 3'd0, 8'h00, 16'h0},
        '{32'h79000000, 3'd1, 5'd4,  1'b0, 1'b0, K_REG, 3'd7, 8'h7F, 16'h0},
        '{32'h71000000, 3'd1, 5'd7,  1'b0, 1'b0, K_MEM, 3'd0, 8'h7F, 16'h4012},
        '{32'h74000000, 3'd1, 5'd7,  1'b0, 1'b0, K_MEM, 3'd0, 8'h40, 16'h4012},
        '{32'hDD710500, 3'd3, 5'd19, 1'b0, 1'b0, K_MEM, 3'd0, 8'h7F, 16'h1005},
        '{32'hFD77FE00, 3'd3, 5'd19, 1'b0, 1'b0, K_MEM, 3'd0, 8'h7F, 16'h1FFE},
        '{32'hDD758000, 3'd3, 5'd19, 1'b0, 1'b0, K_MEM, 3'd0, 8'h12, 16'h0F80},
        '{32'hED470000, 3'd2, 5'd9,  1'b0, 1'b0, K_I,   3'd0, 8'h7F, 16'h0},
        '{32'h3E800000, 3'd2, 5'd7,  1'b0, 1'b0, K_REG, 3'd7, 8'h80, 16'h0},
        '{32'hED4F0000, 3'd2, 5'd9,  1'b0, 1'b0, K_R,   3'd0, 8'h80, 16'h0},
        '{32'hED570000, 3'd2, 5'd9,  1'b1, 1'b0, K_FLG, 3'd0, 8'h04, 16'h0},
        '{32'h3EC30000, 3'd2, 5'd7,  1'b0, 1'b0, K_FLG, 3'd0, 8'h04, 16'h0},
        '{32'hED5F0000, 3'd2, 5'd9,  1'b0, 1'b0, K_FLG, 3'd0, 8'h80, 16'h0},
        '{32'h3E000000, 3'd2, 5'd7,  1'b0, 1'b0, K_REG, 3'd7, 8'h00, 16'h0},
        '{32'hED4F0000, 3'd2, 5'd9,  1'b0, 1'b0, K_R,   3'd0, 8'h00, 16'h0},
        '{32'h3E110000, 3'd2, 5'd7,  1'b0, 1'b0, K_REG, 3'd7, 8'h11, 16'h0},
        '{32'hED5F0000, 3'd2, 5'd9,  1'b1, 1'b1, K_FLG, 3'd0, 8'h40, 16'h0},
        '{32'hED570000, 3'd2, 5'd9,  1'b1, 1'b0, K_FLG, 3'd0, 8'h04, 16'h0},
        '{32'h06550000, 3'd2, 5'd7,  1'b0, 1'b0, K_REG, 3'd0, 8'h55, 16'h0},
        '{32'h46000000, 3'd1, 5'd4,  1'b0, 1'b0, K_REG, 3'd0, 8'h55, 16'h0},
        '{32'h76000000, 3'd1, 5'd4,  1'b0, 1'b0, K_FLG, 3'd0, 8'h04, 16'h0},
        '{32'hDD410000, 3'd2, 5'd8,  1'b0, 1'b0, K_REG, 3'd0, 8'h55, 16'h0},
        '{32'hED000000, 3'd2, 5'd9,  1'b1, 1'b0, K_REG, 3'd7, 8'h7F, 16'h0},
        '{32'h7F000000, 3'd1, 5'd4,  1'b0, 1'b0, K_REG, 3'd7, 8'h7F, 16'h0},
        '{32'h47000000, 3'd1, 5'd4,  1'b0, 1'b0, K_REG, 3'd0, 8'h7F, 16'h0},
        '{32'h00000000, 3'd1, 5'd4,  1'b0, 1'b0, K_NONE, 3'd0, 8'h00, 16'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fetch_addr;
    logic [7:0]  fetch_data;
    logic        iff2 = 1'b0;
    logic        int_req = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [2:0]  rd_sel = 3'd0;
    logic [7:0]  rd_data, i_reg, r_reg, flags;
    logic        done;

    logic [7:0] prog [256];
    int n_chk = 0;
    int n_bad = 0;
    int we_cnt = 0;

    always #5 clk = ~clk;

    assign fetch_data = prog[fetch_addr[7:0]];

    load8_seq u_load8_seq (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .iff2(iff2), .int_req(int_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rd_sel(rd_sel), .rd_data(rd_data), .i_reg(i_reg),
        .r_reg(r_reg), .flags(flags), .done(done)
    );

    always @(posedge clk) if (rst_n && mem_we) we_cnt <= we_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R8: watchdog expired, actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p;
        int pc_exp;
        int t;
        p = 0;
        for (int a = 0; a < 256; a++) prog[a] = 8'h00;
        for (int i = 0; i < NV; i++)
            for (int k = 0; k < int'(TBL[i].nb); k++) begin
                prog[p] = TBL[i].code[31 - 8*k -: 8];
                p++;
            end

        // R9: reset state
        repeat (3) @(negedge clk);
        rd_sel = 3'd7;
        #1;
        check(fetch_addr == 16'h0, "R9 pc", fetch_addr, 0);
        check(!done && !mem_we, "R9 strobes", {done, mem_we}, 0);
        check(flags == 8'h00, "R9 flags", flags, 0);
        check(rd_data == 8'h00 && i_reg == 8'h00 && r_reg == 8'h00, "R9 regs", rd_data, 0);

        rst_n = 1'b1;
        pc_exp = 0;
        // table walk: t counts the falling edges inside one instruction
        for (int i = 0; i < NV - 1; i++) begin
            t = 1;
            iff2 = TBL[i].iff2;
            int_req = TBL[i].irq;
            while (t < 40) begin
                @(negedge clk);
                int_req = 1'b0;
                t++;
                if (done) break;
            end
            // R1 R2 R3 R4 R5 R10 T-state counts
            check(t == int'(TBL[i].tst), "R8 tstates", t, TBL[i].tst);
            if (TBL[i].kind == K_MEM) begin
                check(mem_we && mem_addr == TBL[i].addr, "R4 addr", mem_addr, TBL[i].addr);
                check(mem_wdata == TBL[i].dat, "R3 data", mem_wdata, TBL[i].dat);
            end else begin
                check(!mem_we, "R10 no write", mem_we, 0);
            end
            rd_sel = TBL[i].sel;
            pc_exp += int'(TBL[i].nb);
            @(negedge clk);
            check(fetch_addr == pc_exp[15:0], "R8 pc", fetch_addr, pc_exp);
            case (TBL[i].kind)
                K_REG: check(rd_data == TBL[i].dat, "R1 R2 reg", rd_data, TBL[i].dat);
                K_FLG: check(flags == TBL[i].dat, "R6 R7 flags", flags, TBL[i].dat);
                K_I:   check(i_reg == TBL[i].dat, "R5 I", i_reg, TBL[i].dat);
                K_R:   check(r_reg == TBL[i].dat, "R5 R", r_reg, TBL[i].dat);
                default: ;
            endcase
        end
        check(we_cnt == 5, "R3 write count", we_cnt, 5);

        // R9: reset in mid-run clears state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rd_sel = 3'd0;
        #1;
        check(rd_data == 8'h00 && i_reg == 8'h00, "R9 mid reset regs", rd_data, 0);
        check(fetch_addr == 16'h0 && flags == 8'h00, "R9 mid reset pc", fetch_addr, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule